// File: doc/BRIEF.md
# Synchronous-Frame Reference Current Generator

This block turns three sampled load currents of a three-phase, four-wire power conditioner into three sinusoidal reference currents. The references keep only the fundamental active part of the load current. An external phase tracker supplies the sine and cosine of the grid angle. A dc-bus regulator supplies a signed term that adds to the active command. On each sample strobe the block takes the phase currents to two stationary axes and rotates them into the synchronous frame. It then smooths the d-axis value with a first-order low-pass filter and adds the dc-bus term. Finally it rotates back with the q-axis forced to zero and expands the result to three phases.

The datapath is sequenced by a small state machine with six states:
- `ST_IDLE` waits for `smp_stb` and captures every input (transition idle→axes on an accepted strobe).
- `ST_AXES` registers the stationary-axis pair (→rotate).
- `ST_ROTATE` registers the synchronous d value (→smooth).
- `ST_SMOOTH` steps the filter once (→unrotate).
- `ST_UNROTATE` adds the correction and registers the back-rotated pair (→phases).
- `ST_PHASES` registers the three outputs and raises `ref_vld` (→idle).

Every transition after the strobe is unconditional, so one sample takes six clocks from strobe to strobe. The 5 kHz sample rate leaves a large margin for this.

Top module: `srf_ref_gen`

## Requirements
- R1: A synchronous reset drives `ref_a`, `ref_b`, `ref_c` to zero and `ref_vld` low, and clears the filter state. A zero-input sample after reset therefore yields zero outputs.
- R2: `ref_vld` rises on the fifth rising edge after the edge that accepts `smp_stb` and stays high for exactly one clock. The reference outputs change only together with that pulse.
- R3: A strobe seen while a sample is in progress (any state other than idle) is ignored. Holding `smp_stb` high for six clocks gives one `ref_vld` pulse.
- R4: The arithmetic is two's complement, and the results are bit-exact as follows.
  - `ang_sin` and `ang_cos` are Q1.14, so 16384 means 1.0.
  - The constants are 13378 for sqrt(2/3), 6689 for sqrt(2/3)/2 and 11585 for sqrt(1/2).
  - Each product sum is rounded by adding 8192 and shifting right arithmetically by 14.
  - Intermediates saturate to 14-bit signed and outputs to 12-bit signed.
  - The axes are ds=(13378·a−6689·b−6689·c) and qs=(11585·b−11585·c).
  - The rotation is de=(cos·ds+sin·qs).
  - The filter steps acc+=de−(acc>>>K), and its output is acc>>>K, with K=`LPF_SHIFT`.
  - The command is dcmd=sat(y+dc_corr).
  - The back-rotated pair is df=(cos·dcmd) and qf=(sin·dcmd).
  - The outputs are a=(13378·df), b=(−6689·df+11585·qf) and c=(−6689·df−11585·qf).
- R5: With balanced in-phase sinusoidal currents and zero correction, the settled outputs match the input fundamental of each phase within 4 LSB.
- R6: Adding the same integer to all three phase currents (for example a third harmonic) leaves the outputs exactly unchanged.
- R7: With zero currents, cos=16384, sin=0 and `dc_corr`=100, the first sample after reset gives outputs 82, −41 and −41.
- R8: Outputs saturate at +2047 and −2048 and never wrap. With a settled d command of +4555 the a output is 2047, and with −4556 it is −2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe; accepted only in idle |
| ld_a | input | 12 | Phase a load current, signed |
| ld_b | input | 12 | Phase b load current, signed |
| ld_c | input | 12 | Phase c load current, signed |
| ang_sin | input | 16 | Sine of frame angle, Q1.14 |
| ang_cos | input | 16 | Cosine of frame angle, Q1.14 |
| dc_corr | input | 12 | Signed dc-bus regulator correction |
| ref_a | output | 12 | Phase a reference current, signed |
| ref_b | output | 12 | Phase b reference current, signed |
| ref_c | output | 12 | Phase c reference current, signed |
| ref_vld | output | 1 | One-clock pulse when new references are out |

## Verification
The bench first aims at the filter. It reruns a balanced waveform after a reset with a common-mode third harmonic added. A design that leaks zero-sequence content, or whose filter truncation drifts, would give outputs that differ between the two runs or stray from the fundamental. It also drives the d command past the output range in both directions. There, a missing clamp shows up as a wrapped sign. It holds the strobe high across a whole sample and checks the pulse timing on every sample, which catches a sequencer that restarts mid-sample or emits its pulse a cycle off. Random stimulus with arbitrary angle values and corrections is compared bit for bit against a bench model of the rounding rules.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int COEF_FRAC = 14;
    localparam int C_FULL    = 13378;   // sqrt(2/3) in Q1.14
    localparam int C_HALF    = 6689;    // sqrt(2/3)/2 in Q1.14
    localparam int C_ROOT    = 11585;   // sqrt(1/2) in Q1.14

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AXES,
        ST_ROTATE,
        ST_SMOOTH,
        ST_UNROTATE,
        ST_PHASES
    } srf_state_t;
endpackage

// File: rtl/srf_rndsat.sv
module srf_rndsat #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 14,
    parameter int FRAC  = 14
) (
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y
);
    localparam int EW = IN_W + 1;
    localparam logic signed [EW-1:0] MAXV = EW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [EW-1:0] MINV = ~MAXV;

    logic signed [EW-1:0] xe;
    logic signed [EW-1:0] t;

    assign xe = {x[IN_W-1], x};

    generate
        if (FRAC > 0) begin : g_round
            localparam logic signed [EW-1:0] HALF = EW'(64'sd1 <<< (FRAC - 1));
            assign t = (xe + HALF) >>> FRAC;
        end else begin : g_pass
            assign t = xe;
        end
    endgenerate

    always_comb begin
        if (t > MAXV)
            y = MAXV[OUT_W-1:0];
        else if (t < MINV)
            y = MINV[OUT_W-1:0];
        else
            y = t[OUT_W-1:0];
    end
endmodule

// File: rtl/srf_lpf.sv
module srf_lpf #(
    parameter int IW    = 14,
    parameter int SHIFT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [IW-1:0] x,
    output logic signed [IW-1:0] y
);
    localparam int AW = IW + SHIFT + 1;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] xe;

    assign xe = {{(SHIFT + 1){x[IW-1]}}, x};

    // acc holds y scaled by 2^SHIFT; the floor shift leaves no residue at steady state
    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= acc + xe - (acc >>> SHIFT);
    end

    assign y = acc[SHIFT+IW-1:SHIFT];
endmodule

// File: rtl/srf_ref_gen.sv
module srf_ref_gen #(
    parameter int DW        = 12,
    parameter int TW        = 16,
    parameter int LPF_SHIFT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] ld_a,
    input  logic signed [DW-1:0] ld_b,
    input  logic signed [DW-1:0] ld_c,
    input  logic signed [TW-1:0] ang_sin,
    input  logic signed [TW-1:0] ang_cos,
    input  logic signed [DW-1:0] dc_corr,
    output logic signed [DW-1:0] ref_a,
    output logic signed [DW-1:0] ref_b,
    output logic signed [DW-1:0] ref_c,
    output logic                 ref_vld
);
    import srf_pkg::*;

    localparam int IW = DW + 2;
    localparam int PW = TW + IW + 2;
    localparam logic signed [PW-1:0] KF = PW'(C_FULL);
    localparam logic signed [PW-1:0] KH = PW'(C_HALF);
    localparam logic signed [PW-1:0] KR = PW'(C_ROOT);

    srf_state_t state, nxt;
    logic       accept;

    logic signed [DW-1:0] cap_a, cap_b, cap_c, cap_dc;
    logic signed [TW-1:0] cap_sin, cap_cos;
    logic signed [IW-1:0] ds_r, qs_r, de_r, df_r, qf_r;

    logic signed [PW-1:0] ds_sum, qs_sum, de_sum, df_sum, qf_sum;
    logic signed [IW-1:0] ds_sat, qs_sat, de_sat, df_sat, qf_sat;
    logic signed [IW-1:0] lpf_y, dcmd;
    logic signed [IW:0]   dcmd_sum;
    logic signed [PW-1:0] ph_sum [3];
    logic signed [DW-1:0] ph_sat [3];

    assign accept = (state == ST_IDLE) && smp_stb;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:     nxt = smp_stb ? ST_AXES : ST_IDLE;
            ST_AXES:     nxt = ST_ROTATE;
            ST_ROTATE:   nxt = ST_SMOOTH;
            ST_SMOOTH:   nxt = ST_UNROTATE;
            ST_UNROTATE: nxt = ST_PHASES;
            ST_PHASES:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // arithmetic per stage
    always_comb begin
        ds_sum   = KF * PW'(cap_a) - KH * PW'(cap_b) - KH * PW'(cap_c);
        qs_sum   = KR * PW'(cap_b) - KR * PW'(cap_c);
        de_sum   = PW'(cap_cos) * PW'(ds_r) + PW'(cap_sin) * PW'(qs_r);
        dcmd_sum = (IW+1)'(lpf_y) + (IW+1)'(cap_dc);
        df_sum   = PW'(cap_cos) * PW'(dcmd);
        qf_sum   = PW'(cap_sin) * PW'(dcmd);
        ph_sum[0] = KF * PW'(df_r);
        ph_sum[1] = KR * PW'(qf_r) - KH * PW'(df_r);
        ph_sum[2] = -(KH * PW'(df_r)) - KR * PW'(qf_r);
    end

    srf_rndsat #(.IN_W(PW), .OUT_W(IW), .FRAC(COEF_FRAC)) u_ds (.x(ds_sum), .y(ds_sat));
    srf_rndsat #(.IN_W(PW), .OUT_W(IW), .FRAC(COEF_FRAC)) u_qs (.x(qs_sum), .y(qs_sat));
    srf_rndsat #(.IN_W(PW), .OUT_W(IW), .FRAC(COEF_FRAC)) u_de (.x(de_sum), .y(de_sat));
    srf_rndsat #(.IN_W(IW+1), .OUT_W(IW), .FRAC(0))       u_dc (.x(dcmd_sum), .y(dcmd));
    srf_rndsat #(.IN_W(PW), .OUT_W(IW), .FRAC(COEF_FRAC)) u_df (.x(df_sum), .y(df_sat));
    srf_rndsat #(.IN_W(PW), .OUT_W(IW), .FRAC(COEF_FRAC)) u_qf (.x(qf_sum), .y(qf_sat));

    generate
        for (genvar p = 0; p < 3; p++) begin : g_phase
            srf_rndsat #(.IN_W(PW), .OUT_W(DW), .FRAC(COEF_FRAC)) u_ph (
                .x(ph_sum[p]),
                .y(ph_sat[p])
            );
        end
    endgenerate

    srf_lpf #(.IW(IW), .SHIFT(LPF_SHIFT)) u_lpf (
        .clk (clk),
        .rst (rst),
        .en  (state == ST_SMOOTH),
        .x   (de_r),
        .y   (lpf_y)
    );

    // outputs and stage registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a <= '0; cap_b <= '0; cap_c <= '0; cap_dc <= '0;
            cap_sin <= '0; cap_cos <= '0;
            ds_r <= '0; qs_r <= '0; de_r <= '0; df_r <= '0; qf_r <= '0;
            ref_a <= '0; ref_b <= '0; ref_c <= '0;
            ref_vld <= 1'b0;
        end else begin
            ref_vld <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (smp_stb) begin
                        cap_a   <= ld_a;
                        cap_b   <= ld_b;
                        cap_c   <= ld_c;
                        cap_sin <= ang_sin;
                        cap_cos <= ang_cos;
                        cap_dc  <= dc_corr;
                    end
                end
                ST_AXES: begin
                    ds_r <= ds_sat;
                    qs_r <= qs_sat;
                end
                ST_ROTATE:   de_r <= de_sat;
                ST_SMOOTH:   ;
                ST_UNROTATE: begin
                    df_r <= df_sat;
                    qf_r <= qf_sat;
                end
                ST_PHASES: begin
                    ref_a   <= ph_sat[0];
                    ref_b   <= ph_sat[1];
                    ref_c   <= ph_sat[2];
                    ref_vld <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/srf_ref_gen_chk.sv
module srf_ref_gen_chk #(
    parameter int DW = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 accept,
    input logic                 ref_vld,
    input logic signed [DW-1:0] ref_a,
    input logic signed [DW-1:0] ref_b,
    input logic signed [DW-1:0] ref_c
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ref_a == '0 && ref_b == '0 && ref_c == '0 && !ref_vld));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ref_vld |=> !ref_vld);

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        ref_vld |-> $past(accept, 6));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!ref_vld && !$past(rst)) |-> ($stable(ref_a) && $stable(ref_b) && $stable(ref_c)));

    a_r3_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);
endmodule

bind srf_ref_gen srf_ref_gen_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .ref_vld (ref_vld),
    .ref_a   (ref_a),
    .ref_b   (ref_b),
    .ref_c   (ref_c)
);

// File: tb/sim_srf_ref_gen.sv
module sim_srf_ref_gen;
    localparam int LK = 4;
    localparam real PI = 3.14159265358979;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_stb = 1'b0;
    logic signed [11:0] ld_a = '0, ld_b = '0, ld_c = '0, dc_corr = '0;
    logic signed [15:0] ang_sin = '0, ang_cos = '0;
    logic signed [11:0] ref_a, ref_b, ref_c;
    logic ref_vld;

    int n_chk = 0, n_bad = 0;
    longint m_acc = 0;
    int rec_a [40], rec_b [40], rec_c [40];

    always #5 clk = ~clk;

    srf_ref_gen #(.LPF_SHIFT(LK)) u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb),
        .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c),
        .ang_sin(ang_sin), .ang_cos(ang_cos), .dc_corr(dc_corr),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .ref_vld(ref_vld)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint rs(input longint x, input int frac, input int w);
        longint t, mx;
        t  = (frac > 0) ? ((x + (64'sd1 <<< (frac - 1))) >>> frac) : x;
        mx = (64'sd1 <<< (w - 1)) - 1;
        if (t > mx) return mx;
        if (t < -mx - 1) return -mx - 1;
        return t;
    endfunction

    task automatic model(input int a, input int b, input int c, input int s, input int co,
                         input int d, output int ea, output int eb, output int ec);
        longint ds, qs, de, y, dcmd, df, qf;
        ds = rs(13378 * longint'(a) - 6689 * longint'(b) - 6689 * longint'(c), 14, 14);
        qs = rs(11585 * longint'(b) - 11585 * longint'(c), 14, 14);
        de = rs(longint'(co) * ds + longint'(s) * qs, 14, 14);
        m_acc = m_acc + de - (m_acc >>> LK);
        y = m_acc >>> LK;
        dcmd = rs(y + d, 0, 14);
        df = rs(longint'(co) * dcmd, 14, 14);
        qf = rs(longint'(s) * dcmd, 14, 14);
        ea = int'(rs(13378 * df, 14, 12));
        eb = int'(rs(-6689 * df + 11585 * qf, 14, 12));
        ec = int'(rs(-6689 * df - 11585 * qf, 14, 12));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_acc = 0;
    endtask

    // one sample; checks R2 timing and R4 exactness; returns at negedge after pulse
    task automatic run_sample(input int a, input int b, input int c, input int s, input int co,
                              input int d, output int oa, output int ob, output int oc);
        bit lat_ok;
        int ea, eb, ec;
        ld_a = 12'(a); ld_b = 12'(b); ld_c = 12'(c);
        ang_sin = 16'(s); ang_cos = 16'(co); dc_corr = 12'(d);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        lat_ok = !ref_vld;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (i < 5 && ref_vld) lat_ok = 1'b0;
        end
        lat_ok = lat_ok && ref_vld;
        chk(lat_ok, "R2 valid timing", longint'(ref_vld), 1);
        oa = int'(ref_a); ob = int'(ref_b); oc = int'(ref_c);
        model(a, b, c, s, co, d, ea, eb, ec);
        chk(oa == ea, "R4 ref_a exact", oa, ea);
        chk(ob == eb, "R4 ref_b exact", ob, eb);
        chk(oc == ec, "R4 ref_c exact", oc, ec);
    endtask

    function automatic int q14(input real v);
        return int'($floor(16384.0 * v + 0.5));
    endfunction

    function automatic int rnd(input real v);
        return int'($floor(v + 0.5));
    endfunction

    task automatic wave_run(input bit harm, input bit compare);
        int oa, ob, oc;
        real th;
        int h;
        for (int n = 0; n < 300; n++) begin
            th = 2.0 * PI * n / 50.0;
            h = harm ? rnd(400.0 * $cos(3.0 * th)) : 0;
            run_sample(rnd(1500.0 * $cos(th)) + h,
                       rnd(1500.0 * $cos(th - 2.0 * PI / 3.0)) + h,
                       rnd(1500.0 * $cos(th + 2.0 * PI / 3.0)) + h,
                       q14($sin(th)), q14($cos(th)), 0, oa, ob, oc);
            if (n >= 260) begin
                if (!compare) begin
                    rec_a[n-260] = oa; rec_b[n-260] = ob; rec_c[n-260] = oc;
                    chk(oa - rnd(1500.0 * $cos(th)) <= 4 && rnd(1500.0 * $cos(th)) - oa <= 4,
                        "R5 phase a fundamental", oa, rnd(1500.0 * $cos(th)));
                    chk(ob - rnd(1500.0 * $cos(th - 2.0 * PI / 3.0)) <= 4 &&
                        rnd(1500.0 * $cos(th - 2.0 * PI / 3.0)) - ob <= 4,
                        "R5 phase b fundamental", ob, rnd(1500.0 * $cos(th - 2.0 * PI / 3.0)));
                    chk(oc - rnd(1500.0 * $cos(th + 2.0 * PI / 3.0)) <= 4 &&
                        rnd(1500.0 * $cos(th + 2.0 * PI / 3.0)) - oc <= 4,
                        "R5 phase c fundamental", oc, rnd(1500.0 * $cos(th + 2.0 * PI / 3.0)));
                end else begin
                    chk(oa == rec_a[n-260], "R6 zero-sequence a", oa, rec_a[n-260]);
                    chk(ob == rec_b[n-260], "R6 zero-sequence b", ob, rec_b[n-260]);
                    chk(oc == rec_c[n-260], "R6 zero-sequence c", oc, rec_c[n-260]);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int oa, ob, oc, pulses;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_acc = 0;
        chk(ref_a == 0 && ref_b == 0 && ref_c == 0, "R1 reset outputs", ref_a, 0);
        chk(!ref_vld, "R1 reset valid", ref_vld, 0);

        // R7 directed correction path
        run_sample(0, 0, 0, 0, 16384, 100, oa, ob, oc);
        chk(oa == 82, "R7 ref_a", oa, 82);
        chk(ob == -41, "R7 ref_b", ob, -41);
        chk(oc == -41, "R7 ref_c", oc, -41);

        // R3 strobe held through a whole sample
        do_reset();
        ld_a = '0; ld_b = '0; ld_c = '0; ang_sin = '0; ang_cos = 16'sd16384; dc_corr = 12'sd50;
        smp_stb = 1'b1;
        pulses = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (i == 5) smp_stb = 1'b0;
            if (ref_vld) pulses++;
        end
        chk(pulses == 1, "R3 busy strobe ignored", pulses, 1);
        chk(ref_a == 41, "R3 single update", ref_a, 41);

        // R4 constrained random
        do_reset();
        for (int n = 0; n < 200; n++) begin
            run_sample(int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048,
                       int'($urandom % 4096) - 2048, int'($urandom % 32769) - 16384,
                       int'($urandom % 32769) - 16384, int'($urandom % 4096) - 2048,
                       oa, ob, oc);
        end

        // R5 balanced waveform, then R6 with common third harmonic
        do_reset();
        wave_run(1'b0, 1'b0);
        do_reset();
        wave_run(1'b1, 1'b1);

        // R8 saturation both ways
        do_reset();
        for (int n = 0; n < 250; n++) run_sample(2047, -1024, -1024, 0, 16384, 2047, oa, ob, oc);
        chk(oa == 2047, "R8 positive clamp", oa, 2047);
        do_reset();
        for (int n = 0; n < 250; n++) run_sample(-2048, 1024, 1024, 0, 16384, -2048, oa, ob, oc);
        chk(oa == -2048, "R8 negative clamp", oa, -2048);

        // R1 reset clears outputs and filter
        do_reset();
        chk(ref_a == 0 && ref_b == 0 && ref_c == 0, "R1 outputs cleared", ref_a, 0);
        run_sample(0, 0, 0, 0, 16384, 0, oa, ob, oc);
        chk(oa == 0, "R1 filter cleared", oa, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule